// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block turns a set of asynchronous, active-low interrupt pins into clean per-pin request lines for an interrupt controller. Each pin is synchronised to the core clock and then captured only on cycles flagged by a machine-cycle enable. A per-pin trigger-select input chooses how the request behaves. In falling-edge mode the request is a latched flag, set by hardware when a high-to-low transition is seen. In low-level mode the request simply follows the most recent sample of the pin.

A latched flag is cleared by a software clear strobe, or automatically by the acknowledge strobe that the controller raises when it vectors to the service routine. A set that meets a clear in the same cycle takes precedence, so a fresh event is never dropped. Priority, vectoring and register decoding sit outside this block. The number of pins and the synchroniser depth are parameters.

Top module: `xirq_request`

## Requirements
- R1: During reset and on the first cycle after it, every `req` bit is 0. The synchroniser and the sample register come out of reset as logic 1 (idle high), so a pin held high through reset produces no request.
- R2: Each pin passes through SYNC_STAGES clocked flops and is then captured only on clock edges where `cyc_en` is 1. With the default depth of 2, a pin change made just after one edge is captured at the third edge, provided `cyc_en` is 1 at that edge. A low pulse that is over before any capture with `cyc_en` = 1 has no effect on `req`.
- R3: Falling-edge mode is selected by `edge_sel[p]` = 1. In this mode, a capture of 0 that directly follows a captured 1 sets `req[p]` at that same clock edge.
- R4: In falling-edge mode a set flag stays 1 until it is cleared, whatever the pin does. A pin that stays low does not set the flag again after it has been cleared.
- R5: In falling-edge mode, `sw_clr[p]` = 1 or `vec_ack[p]` = 1 clears `req[p]` at the next clock edge.
- R6: If a falling edge is detected at the same clock edge as `sw_clr[p]` or `vec_ack[p]`, the flag ends up set.
- R7: Low-level mode is selected by `edge_sel[p]` = 0. In this mode `req[p]` is 1 exactly while the latest capture of the pin is 0. It is not latched, and `sw_clr` and `vec_ack` have no effect on it.
- R8: While `edge_sel[p]` = 0 the latched flag is held at 0. After a switch to falling-edge mode with the pin already low, `req[p]` stays 0 until a new high-to-low transition is captured.
- R9: The pins are independent: activity, clears or acknowledges on one pin never change `req` of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| pin_n | input | N_PINS | Asynchronous active-low interrupt pins |
| cyc_en | input | 1 | Machine-cycle sample enable |
| edge_sel | input | N_PINS | Per-pin trigger select: 1 = falling edge, 0 = low level |
| sw_clr | input | N_PINS | Per-pin software clear strobe for the latched flag |
| vec_ack | input | N_PINS | Per-pin vector-acknowledge strobe for the latched flag |
| req | output | N_PINS | Per-pin interrupt request |

## Verification
The setting of a flag by a captured falling edge and its clearing by the software strobe or the acknowledge strobe can land on the same clock edge. The bench provokes this on purpose: it drives the pin low, counts the synchroniser and sample latency, and raises `sw_clr` in one run and `vec_ack` in another so that the strobe is present at exactly the capture edge. It then expects the flag to be set. Random traffic with frequent strobes produces further collisions, and each one is judged against a cycle-accurate bench model that gives the set precedence.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_FALL  = 1'b1
   } trig_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '1;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
      end
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/xirq_sampler.sv
module xirq_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_en,
   input  logic level_in,
   output logic held,
   output logic fall_seen
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= 1'b1;
      end else if (sample_en) begin
         held <= level_in;
      end
   end

   // previous capture high, capture being taken now low
   assign fall_seen = sample_en & held & ~level_in;

endmodule

// File: rtl/xirq_flag.sv
module xirq_flag
   import xirq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  trig_e trig,
   input  logic  fall_seen,
   input  logic  held,
   input  logic  sw_clr,
   input  logic  vec_ack,
   output logic  req
);

   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (trig == TRIG_LEVEL) begin
         flag_q <= 1'b0;
      end else if (fall_seen) begin
         flag_q <= 1'b1;
      end else if (sw_clr || vec_ack) begin
         flag_q <= 1'b0;
      end
   end

   assign req = (trig == TRIG_FALL) ? flag_q : ~held;

endmodule

// File: rtl/xirq_request.sv
module xirq_request
   import xirq_pkg::*;
#(
   parameter int unsigned N_PINS      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_n,
   input  logic              cyc_en,
   input  logic [N_PINS-1:0] edge_sel,
   input  logic [N_PINS-1:0] sw_clr,
   input  logic [N_PINS-1:0] vec_ack,
   output logic [N_PINS-1:0] req
);

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("xirq_request: SYNC_STAGES must be at least %0d", MIN_SYNC_STAGES);
   end
   if (N_PINS < 1) begin : g_bad_pins
      $error("xirq_request: N_PINS must be at least 1");
   end

   logic [N_PINS-1:0] pin_sync;
   logic [N_PINS-1:0] pin_held;
   logic [N_PINS-1:0] fall_hit;

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (pin_n[p]),
         .sync_out (pin_sync[p])
      );

      xirq_sampler u_smp (
         .clk       (clk),
         .rst_n     (rst_n),
         .sample_en (cyc_en),
         .level_in  (pin_sync[p]),
         .held      (pin_held[p]),
         .fall_seen (fall_hit[p])
      );

      xirq_flag u_flag (
         .clk       (clk),
         .rst_n     (rst_n),
         .trig      (trig_e'(edge_sel[p])),
         .fall_seen (fall_hit[p]),
         .held      (pin_held[p]),
         .sw_clr    (sw_clr[p]),
         .vec_ack   (vec_ack[p]),
         .req       (req[p])
      );
   end

endmodule

// File: rtl/xirq_request_chk.sv
module xirq_request_chk #(
   parameter int unsigned N_PINS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_en,
   input logic [N_PINS-1:0] edge_sel,
   input logic [N_PINS-1:0] sw_clr,
   input logic [N_PINS-1:0] vec_ack,
   input logic [N_PINS-1:0] fall_hit,
   input logic [N_PINS-1:0] req
);

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req == '0)); // R1

   for (genvar i = 0; i < N_PINS; i++) begin : g_chk
      AST_LEVEL_NO_SAMPLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (!edge_sel[i] && $past(!edge_sel[i]) && $past(!cyc_en)) |-> $stable(req[i])); // R2

      AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_sel[i] && fall_hit[i]) |=> (req[i] || !edge_sel[i])); // R6

      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_sel[i] && req[i] && !sw_clr[i] && !vec_ack[i]) |=> (req[i] || !edge_sel[i])); // R4

      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_sel[i] && (sw_clr[i] || vec_ack[i]) && !fall_hit[i]) |=> (!req[i] || !edge_sel[i])); // R5

      AST_NO_SET_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_sel[i] && !req[i] && !fall_hit[i]) |=> (!req[i] || !edge_sel[i])); // R3

      AST_LEVEL_MODE_SWITCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
         (!edge_sel[i] && !fall_hit[i]) |=> (!req[i] || !edge_sel[i])); // R8
   end

endmodule

bind xirq_request xirq_request_chk #(.N_PINS(N_PINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cyc_en   (cyc_en),
   .edge_sel (edge_sel),
   .sw_clr   (sw_clr),
   .vec_ack  (vec_ack),
   .fall_hit (fall_hit),
   .req      (req)
);

// File: tb/xirq_request_test.sv
module xirq_request_test;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 2;
   localparam int SYNC       = 2;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] pin_n, edge_sel, sw_clr, vec_ack, req;
   logic         cyc_en;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xirq_request #(.N_PINS(N), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .cyc_en(cyc_en),
      .edge_sel(edge_sel), .sw_clr(sw_clr), .vec_ack(vec_ack), .req(req)
   );

   // cycle model built from the requirements
   logic [N-1:0] m_sync [SYNC];
   logic [N-1:0] m_smp, m_flag;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC; s++) m_sync[s] <= '1;
         m_smp  <= '1;
         m_flag <= '0;
      end else begin
         m_sync[0] <= pin_n;
         for (int s = 1; s < SYNC; s++) m_sync[s] <= m_sync[s-1];
         if (cyc_en) m_smp <= m_sync[SYNC-1];
         for (int p = 0; p < N; p++) begin
            if (!edge_sel[p])                                       m_flag[p] <= 1'b0;
            else if (cyc_en && m_smp[p] && !m_sync[SYNC-1][p])      m_flag[p] <= 1'b1;
            else if (sw_clr[p] || vec_ack[p])                       m_flag[p] <= 1'b0;
         end
      end
   end

   function automatic logic exp_req(int p);
      if (!rst_n) return 1'b0;
      return edge_sel[p] ? m_flag[p] : ~m_smp[p];
   endfunction

   task automatic want(input int p, input logic val, input string tag);
      checks++;
      if (req[p] !== val) begin
         errors++;
         $display("FAIL %s pin %0d: req=%b expected=%b at %0t", tag, p, req[p], val, $time);
      end
   endtask

   task automatic step(input string tag);
      @(negedge clk);
      for (int p = 0; p < N; p++) want(p, exp_req(p), tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) step(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1c01));
      rst_n = 1'b0; pin_n = '1; cyc_en = 1'b1; edge_sel = '1; sw_clr = '0; vec_ack = '0;
      // R1: reset state
      idle(3, "R1 in reset");
      rst_n = 1'b1;
      step("R1 first cycle");
      want(0, 1'b0, "R1 after reset"); want(1, 1'b0, "R1 after reset");
      idle(4, "R1 idle-high");

      // R3: latency of a falling edge, pin 0
      pin_n[0] = 1'b0;
      step("R3"); want(0, 1'b0, "R3 sync stage 1");
      step("R3"); want(0, 1'b0, "R3 sync stage 2");
      step("R3"); want(0, 1'b1, "R3 set at capture");
      want(1, 1'b0, "R9 other pin quiet");

      // R4: stays set, held-low pin does not retrigger after clear
      idle(3, "R4 hold");
      want(0, 1'b1, "R4 flag held");
      sw_clr[0] = 1'b1; step("R5 sw clear"); sw_clr[0] = 1'b0;
      want(0, 1'b0, "R5 sw clear");
      idle(5, "R4 no retrigger");
      want(0, 1'b0, "R4 no retrigger while low");

      // R5: acknowledge clears
      pin_n[0] = 1'b1; idle(4, "R5 restore");
      pin_n[0] = 1'b0; idle(3, "R5 set");
      vec_ack[0] = 1'b1; step("R5 ack"); vec_ack[0] = 1'b0;
      want(0, 1'b0, "R5 ack clears");

      // R6: set beats clear at the same edge (software clear, then acknowledge)
      pin_n[0] = 1'b1; idle(4, "R6 restore");
      pin_n[0] = 1'b0; idle(2, "R6 pipe");
      sw_clr[0] = 1'b1; step("R6 set vs sw_clr"); sw_clr[0] = 1'b0;
      want(0, 1'b1, "R6 set vs sw_clr");
      vec_ack[0] = 1'b1; step("R6 clear after"); vec_ack[0] = 1'b0;
      pin_n[0] = 1'b1; idle(4, "R6 restore");
      pin_n[0] = 1'b0; idle(2, "R6 pipe");
      vec_ack[0] = 1'b1; step("R6 set vs vec_ack"); vec_ack[0] = 1'b0;
      want(0, 1'b1, "R6 set vs vec_ack");
      sw_clr[0] = 1'b1; step("R5"); sw_clr[0] = 1'b0;
      pin_n[0] = 1'b1; idle(4, "restore");

      // R7: level mode follows the sample, strobes ignored
      edge_sel[1] = 1'b0; step("R7 mode");
      pin_n[1] = 1'b0; idle(3, "R7 low");
      want(1, 1'b1, "R7 low level requests");
      sw_clr[1] = 1'b1; vec_ack[1] = 1'b1; step("R7 strobes"); sw_clr[1] = 1'b0; vec_ack[1] = 1'b0;
      want(1, 1'b1, "R7 strobes ignored");
      want(0, 1'b0, "R9 pin0 unaffected");
      pin_n[1] = 1'b1; idle(3, "R7 high");
      want(1, 1'b0, "R7 not latched");

      // R8: edge seen in level mode is not carried into edge mode
      pin_n[1] = 1'b0; idle(4, "R8 low in level");
      edge_sel[1] = 1'b1; step("R8 switch");
      want(1, 1'b0, "R8 no stale flag");
      idle(4, "R8 stay");
      pin_n[1] = 1'b1; idle(4, "R8 restore");

      // R2: short pulse while sampling is off is missed
      cyc_en = 1'b0;
      pin_n[0] = 1'b0; idle(3, "R2 pulse");
      pin_n[0] = 1'b1; idle(3, "R2 pulse end");
      cyc_en = 1'b1; idle(3, "R2 resume");
      want(0, 1'b0, "R2 unsampled pulse ignored");

      // random traffic
      for (int it = 0; it < 4000; it++) begin
         for (int p = 0; p < N; p++) begin
            if ($urandom % 6 == 0)  pin_n[p]    = ~pin_n[p];
            if ($urandom % 50 == 0) edge_sel[p] = ~edge_sel[p];
            sw_clr[p]  = ($urandom % 8 == 0);
            vec_ack[p] = ($urandom % 8 == 0);
         end
         cyc_en = ($urandom % 4 != 0);
         step("R3/R5/R7 random R6 R9");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule